// File: doc/BRIEF.md
# ECP Forward Channel Transmitter

This block is the host-side transmitter for the forward direction of an extended-capabilities parallel port. System logic writes bytes into a 16-entry FIFO through a valid/ready port. Each entry carries a tag that marks it as a data byte or as a command/address byte. While the channel is enabled in the forward direction, the block takes entries from the FIFO in order. For each entry it drives the eight cable data lines and the host-ack line, which carries the tag, and then runs a fully interlocked handshake with the peripheral on the active-low strobe and the peripheral's busy line.

The block does no negotiation. It moves bytes whenever the enable input is high and the peripheral is not busy. The busy line comes from the cable, so it is synchronised before use. If a handshake phase stalls for more than a programmable number of clocks, the block sets a sticky timeout flag, releases the strobe and returns to idle. The byte in flight is dropped.

Top module: `ecp_fwd_tx`

## Requirements
- R1: After reset the strobe is high, the data-line enable is low, host-ack is high, the FIFO is empty (count 0, empty 1, full 0) and the overflow and timeout flags are 0.
- R2: The FIFO holds 16 entries. The count output gives the occupancy. Full is asserted at 16 entries, and write-ready equals not-full.
- R3: A write while full is ignored: the count and the stored contents are unchanged. The write sets the overflow flag, which stays set until reset.
- R4: Bytes leave in FIFO order. While a byte is on the data lines, host-ack is 0 for a command/address entry (write tag 1) and 1 for a data entry (write tag 0).
- R5: The data lines and host-ack are stable for at least one clock before the strobe falls. They stay unchanged until the strobe rises again.
- R6: The strobe never falls while the synchronised busy line is high. An entry stays in the FIFO while busy is held high.
- R7: Interlock: once low, the strobe stays low until busy is seen high. The next strobe does not fall until busy has been seen low again.
- R8: If busy fails to rise after the strobe falls, or fails to fall after the strobe rises, for more than the programmed timeout limit in clocks, the timeout flag sets and stays set until reset. The strobe is high at that point, and the block returns to idle.
- R9: While the enable input is low, no new byte starts. The data-line enable follows the enable input and stays high while a handshake is in progress. The strobe is never low while the data-line enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_en_i | input | 1 | Forward channel enabled |
| to_limit_i | input | 16 | Handshake timeout limit in clocks |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | FIFO can accept a write |
| wr_data_i | input | 8 | Byte to send |
| wr_cmd_i | input | 1 | 1 = command/address entry, 0 = data entry |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| count_o | output | 5 | FIFO occupancy |
| overflow_o | output | 1 | Sticky write-when-full flag |
| timeout_o | output | 1 | Sticky handshake timeout flag |
| pd_o | output | 8 | Cable data lines |
| pd_oe_o | output | 1 | Data line output enable |
| hostack_o | output | 1 | Host-ack line: 1 data, 0 command/address |
| strobe_no | output | 1 | Strobe, active low |
| busy_i | input | 1 | Peripheral busy line |

## Verification
Three delays set when each result appears:
- A write shows in count, full, empty and overflow one clock after the edge that takes it.
- With an idle channel and busy low, the data lines and host-ack change one edge after that. The strobe falls on the following edge.
- A change on busy reaches the handshake after two synchroniser stages, and the strobe answers on the next edge.

The bench drives inputs and samples outputs on falling clock edges. Checks that depend on a handshake wait on the observed strobe level and do not assume a fixed count, so the synchroniser depth does not matter to them. Stall and timeout checks are sampled many cycles past the point where the outcome is settled.

// File: rtl/ecp_tx_pkg.sv
package ecp_tx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              is_cmd;
    logic [BYTE_W-1:0] byte_v;
  } tx_item_t;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_SETUP,
    HS_STROBE,
    HS_RELEASE
  } hs_state_e;
endpackage

// File: rtl/ecp_tx_fifo.sv
module ecp_tx_fifo
  import ecp_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  tx_item_t item_i,
  input  logic     pop_i,
  output tx_item_t item_o,
  output logic     full_o,
  output logic     empty_o,
  output logic [CW-1:0] count_o,
  output logic     overflow_o
);
  tx_item_t        mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]   cnt_q;
  logic            ovf_q;
  logic            do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign overflow_o = ovf_q;
  assign item_o  = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= item_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)) && overflow_o);
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  assert_sticky_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_pop_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ecp_tx_sync.sv
module ecp_tx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecp_tx_hs.sv
module ecp_tx_hs
  import ecp_tx_pkg::*;
#(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            avail_i,
  input  tx_item_t        item_i,
  input  logic            busy_s_i,
  input  logic [TO_W-1:0] to_limit_i,
  output logic            pop_o,
  output logic            active_o,
  output logic [BYTE_W-1:0] pd_o,
  output logic            hostack_o,
  output logic            strobe_no,
  output logic            timeout_o
);
  hs_state_e         state_q;
  logic [TO_W-1:0]   cnt_q;
  logic [BYTE_W-1:0] pd_q;
  logic              hostack_q, strobe_q, to_q;
  logic              expired;

  assign expired   = (cnt_q == to_limit_i);
  assign pop_o     = (state_q == HS_IDLE) && en_i && avail_i && !busy_s_i;
  assign active_o  = (state_q != HS_IDLE);
  assign pd_o      = pd_q;
  assign hostack_o = hostack_q;
  assign strobe_no = strobe_q;
  assign timeout_o = to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= HS_IDLE;
      cnt_q     <= '0;
      pd_q      <= '0;
      hostack_q <= 1'b1;
      strobe_q  <= 1'b1;
      to_q      <= 1'b0;
    end else begin
      unique case (state_q)
        HS_IDLE: if (pop_o) begin
          pd_q      <= item_i.byte_v;
          hostack_q <= !item_i.is_cmd;
          state_q   <= HS_SETUP;
        end
        HS_SETUP: if (!busy_s_i) begin
          strobe_q <= 1'b0;
          cnt_q    <= '0;
          state_q  <= HS_STROBE;
        end
        HS_STROBE: begin
          if (busy_s_i) begin
            strobe_q <= 1'b1;
            cnt_q    <= '0;
            state_q  <= HS_RELEASE;
          end else if (expired) begin
            strobe_q <= 1'b1;
            to_q     <= 1'b1;
            state_q  <= HS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HS_RELEASE: begin
          if (!busy_s_i) begin
            state_q <= HS_IDLE;
          end else if (expired) begin
            to_q    <= 1'b1;
            state_q <= HS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assert_setup_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> $stable(pd_o) && $stable(hostack_o));
  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |=> $stable(pd_o) && $stable(hostack_o));
  assert_no_strobe_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> !$past(busy_s_i));
  assert_interlock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_no) |-> $past(busy_s_i) || $rose(timeout_o));
  assert_timeout_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> strobe_no && !active_o);
  assert_timeout_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);
endmodule

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx
  import ecp_tx_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic [TO_W-1:0]   to_limit_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_cmd_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o,
  output logic              overflow_o,
  output logic              timeout_o,
  output logic [BYTE_W-1:0] pd_o,
  output logic              pd_oe_o,
  output logic              hostack_o,
  output logic              strobe_no,
  input  logic              busy_i
);
  tx_item_t wr_item, rd_item;
  logic     pop, busy_s, hs_active, oe_q;

  assign wr_item.is_cmd = wr_cmd_i;
  assign wr_item.byte_v = wr_data_i;
  assign wr_ready_o     = !full_o;

  ecp_tx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i    (wr_valid_i),
    .item_i    (wr_item),
    .pop_i     (pop),
    .item_o    (rd_item),
    .full_o, .empty_o, .count_o, .overflow_o
  );

  ecp_tx_sync #(.STAGES(SYNC_STAGES)) i_busy_sync (
    .clk_i, .rst_ni,
    .d_i (busy_i),
    .q_o (busy_s)
  );

  ecp_tx_hs #(.TO_W(TO_W)) i_hs (
    .clk_i, .rst_ni,
    .en_i       (fwd_en_i),
    .avail_i    (!empty_o),
    .item_i     (rd_item),
    .busy_s_i   (busy_s),
    .to_limit_i (to_limit_i),
    .pop_o      (pop),
    .active_o   (hs_active),
    .pd_o, .hostack_o, .strobe_no, .timeout_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= fwd_en_i || hs_active;
  end
  assign pd_oe_o = oe_q;

  assert_oe_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_oe_o |-> strobe_no);
  assert_no_start_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_en_i && !hs_active) |=> strobe_no);
endmodule

// File: tb/test_ecp_fwd_tx.sv
module test_ecp_fwd_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fwd_en = 1'b0;
  logic [15:0] to_limit = 16'd1000;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_cmd = 1'b0;
  logic       busy_force = 1'b0, busy_resp = 1'b0;
  logic       busy;
  logic       wr_ready, full, empty, overflow, timeout, pd_oe, hostack, strobe_n;
  logic [4:0] count;
  logic [7:0] pd;

  int checks = 0, failures = 0, rx_cnt = 0;
  bit resp_en = 1'b0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;
  assign busy = busy_force | busy_resp;

  ecp_fwd_tx i_ecp_fwd_tx (
    .clk_i(clk), .rst_ni(rst_n), .fwd_en_i(fwd_en), .to_limit_i(to_limit),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data), .wr_cmd_i(wr_cmd),
    .full_o(full), .empty_o(empty), .count_o(count), .overflow_o(overflow),
    .timeout_o(timeout), .pd_o(pd), .pd_oe_o(pd_oe), .hostack_o(hostack),
    .strobe_no(strobe_n), .busy_i(busy)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver: one write per call; expect=1 queues the cable value {hostack, byte}
  task automatic push(logic [7:0] b, logic is_cmd, bit expect_tx, bit wait_ready);
    @(negedge clk);
    while (wait_ready && !wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = b; wr_cmd = is_cmd;
    if (expect_tx) exp_q.push_back({!is_cmd, b});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !empty || !strobe_n || busy_resp) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    repeat (10) @(negedge clk);
  endtask

  // peripheral model and monitor
  initial begin : periph
    logic [8:0] last, cur, got;
    last = '0;
    forever begin
      @(negedge clk);
      cur = {hostack, pd};
      if (resp_en && rst_n && !strobe_n) begin
        chk(cur == last, "R5", "setup before strobe", cur, last);
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected byte", cur, 0);
        else begin
          got = exp_q.pop_front();
          chk(cur == got, "R4", "order/tag", cur, got);
        end
        rx_cnt++;
        repeat (3) begin
          @(negedge clk);
          chk(!strobe_n, "R7", "strobe held until busy", strobe_n, 0);
        end
        busy_resp = 1'b1;
        while (!strobe_n) begin
          @(negedge clk);
          chk({hostack, pd} == cur, "R5", "hold while strobed", {hostack, pd}, cur);
        end
        repeat (2) @(negedge clk);
        chk(strobe_n, "R7", "no strobe while busy", strobe_n, 1);
        busy_resp = 1'b0;
        cur = {hostack, pd};
      end
      last = cur;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(strobe_n === 1'b1, "R1", "strobe", strobe_n, 1);
    chk(pd_oe === 1'b0, "R1", "pd_oe", pd_oe, 0);
    chk(hostack === 1'b1, "R1", "hostack", hostack, 1);
    chk(empty && !full && count == 0, "R1", "fifo", count, 0);
    chk(!overflow && !timeout, "R1", "flags", {overflow, timeout}, 0);

    // R2/R3/R9: fill while disabled
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), (i % 3) == 0, 1'b1, 1'b0);
    @(negedge clk);
    chk(count == 16 && full && !wr_ready, "R2", "full at 16", count, 16);
    chk(strobe_n && !pd_oe, "R9", "idle when disabled", {strobe_n, pd_oe}, 2);
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(count == 16, "R3", "write when full ignored", count, 16);
    chk(overflow, "R3", "overflow set", overflow, 1);

    // R4: drain in order with tags
    resp_en = 1'b1;
    fwd_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(pd_oe, "R9", "oe follows enable", pd_oe, 1);
    wait_drain();
    chk(rx_cnt == 16, "R3", "dropped byte never sent", rx_cnt, 16);
    chk(empty && count == 0, "R2", "empty after drain", count, 0);
    chk(overflow, "R3", "overflow sticky", overflow, 1);

    // R4: streaming pattern while sending
    for (int i = 0; i < 24; i++) push(8'(i * 37 + 5), i[0], 1'b1, 1'b1);
    wait_drain();
    chk(rx_cnt == 40, "R4", "stream count", rx_cnt, 40);

    // R6: busy held high blocks start
    busy_force = 1'b1;
    repeat (4) @(negedge clk);
    push(8'hA5, 1'b1, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(strobe_n, "R6", "no strobe while busy", strobe_n, 1);
    chk(count == 1, "R6", "entry kept", count, 1);
    busy_force = 1'b0;
    wait_drain();
    chk(rx_cnt == 41, "R6", "sent after busy low", rx_cnt, 41);

    // R8: peripheral silent
    resp_en = 1'b0;
    to_limit = 16'd20;
    push(8'h5A, 1'b0, 1'b0, 1'b1);
    repeat (8) @(negedge clk);
    chk(!strobe_n && !timeout, "R8", "strobe low before limit", {strobe_n, timeout}, 0);
    repeat (60) @(negedge clk);
    chk(timeout, "R8", "timeout set", timeout, 1);
    chk(strobe_n, "R8", "strobe released", strobe_n, 1);
    chk(empty, "R8", "idle with empty fifo", empty, 1);
    repeat (10) @(negedge clk);
    chk(timeout && strobe_n, "R8", "sticky, stays idle", {timeout, strobe_n}, 3);

    // R9: disable stops new starts
    fwd_en = 1'b0;
    repeat (3) @(negedge clk);
    push(8'h77, 1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk(strobe_n && !pd_oe && count == 1, "R9", "no start when disabled", {strobe_n, pd_oe, count}, 9'h41);

    // R1: reset clears
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!timeout && !overflow && empty && strobe_n && !pd_oe, "R1", "reset clears", {timeout, overflow, empty}, 1);

    finish_sim();
  end
endmodule